// File: doc/BRIEF.md
# Two-Level I/O Address Translator

This block turns the I/O address that a device puts out into a real memory address. It walks two tables held in memory. The upper bits of the I/O address select one entry in a segment table. That entry points to a page table, sets its own page size and sets how long its page table is. The translator then fetches the page table entry and forms the real address from it. Both table fetches go out on a simple read port. The memory answers each fetch with one response word after any latency.

A requester presents an I/O address, a direction flag and an 11-bit requester identity. The block takes one request at a time. It answers with a single response pulse that carries either a real address or a fault code. The code tells a segment-level fault apart from a page-level fault. Translation is gated by two control words: the table-origin word, which also holds the segment table location, and a command-configuration word. When translation is not switched on, the I/O address passes through unchanged.

Top module: `iox_walker`

## Requirements
- R1: When `originReg[63]` or `cmdCfg[47]` is 0 at the moment a request is accepted, no memory read is issued. `rspValid` rises in the cycle after acceptance, with `rspFault` = 00 and `rspAddr` equal to the zero-extended I/O address.
- R2: With translation on, the first memory read goes to `{originReg[51:12], 12'h000} + 8 * (reqAddr >> 28)`.
- R3: Segment entry bits 2:0 select the page size: 001 for 4 KB (shift 12), 011 for 64 KB (shift 16), 101 for 1 MB (shift 20) and 111 for 16 MB (shift 24). On success, `rspAddr` is `{pte[51:12], 12'h000}` with its low `shift` bits replaced by the same bits of the I/O address.
- R4: A segment entry with bit 63 clear, or with a size code whose bit 0 is 0, gives a segment fault (`rspFault` = 01). No page entry read follows.
- R5: The page index is `reqAddr[27:shift]`. An index at or above `(ste[11:5] + 1) * 512` gives a segment fault with no page entry read.
- R6: The second memory read goes to `{ste[51:12], 12'h000} + 8 * pageIndex`.
- R7: A page entry equal to zero gives a page fault (`rspFault` = 10). Whenever `rspFault` is not 00, `rspAddr` is 0.
- R8: Page entry bit 63 grants read and bit 62 grants write. A request with `reqWrite` = 1 needs bit 62, and one with `reqWrite` = 0 needs bit 63. A missing permission gives a page fault.
- R9: Page entry bits 10:0 must equal `reqId`; a mismatch gives a page fault.
- R10: `reqReady` stays low from the acceptance of a request until the cycle after its response. `rspValid` and `memReqValid` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| originReg | input | 64 | Table-origin word: bit 63 enable, bits 51:12 segment table page |
| cmdCfg | input | 64 | Command-configuration word: bit 47 translate enable |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqAddr | input | 36 | I/O address |
| reqWrite | input | 1 | 1 = device writes memory, 0 = device reads |
| reqId | input | 11 | Requester identity |
| memReqValid | output | 1 | Table read request pulse |
| memReqAddr | output | 52 | Real address of the table word to read |
| memRspValid | input | 1 | Table read data present |
| memRspData | input | 64 | Table word returned |
| rspValid | output | 1 | Translation result pulse |
| rspAddr | output | 52 | Real address, or 0 on a fault |
| rspFault | output | 2 | 00 none, 01 segment fault, 10 page fault |

## Verification
The embedded properties watch the handshake on every cycle: a busy unit never shows ready, the pulses never stretch, a bypassed request answers in the next cycle without touching memory, a rejected segment entry is never followed by a second fetch, and a faulted result never carries an address. The arithmetic cannot be checked that way. Each page-size decode, the two fetch addresses, the bounds limit, the offset splice and the priority among permission, identity and empty-entry faults are only shown by the directed scenarios, which compare against table contents the bench lays out itself.

// File: rtl/iox_pkg.sv
package iox_pkg;

  localparam int SEG_SHIFT = 28;
  localparam int PG_MIN    = 12;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_SEG  = 2'b01,
    FLT_PAGE = 2'b10
  } iox_fault_e;

  typedef struct packed {
    logic takeReq;
    logic bypass;
    logic takeSte;
    logic takePte;
    logic usePte;
  } iox_strobe_t;

  // page shift for a size code, 0 marks an unusable code
  function automatic logic [4:0] pageShift(input logic [2:0] code);
    case (code)
      3'b001:  pageShift = 5'd12;
      3'b011:  pageShift = 5'd16;
      3'b101:  pageShift = 5'd20;
      3'b111:  pageShift = 5'd24;
      default: pageShift = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/iox_ctrl.sv
module iox_ctrl
  import iox_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        xlateOn,
  input  logic        memRspValid,
  input  logic        steBad,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        rspValid,
  output iox_strobe_t stb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_STE_REQ, ST_STE_WAIT, ST_PTE_REQ, ST_PTE_WAIT, ST_DONE
  } walkState_e;

  walkState_e state, stateNext;

  always_comb begin
    stateNext   = state;
    stb         = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    rspValid    = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.takeReq = 1'b1;
          stb.bypass  = !xlateOn;
          stateNext   = xlateOn ? ST_STE_REQ : ST_DONE;
        end
      end
      ST_STE_REQ: begin
        memReqValid = 1'b1;
        stateNext   = ST_STE_WAIT;
      end
      ST_STE_WAIT: begin
        if (memRspValid) begin
          stb.takeSte = 1'b1;
          stateNext   = steBad ? ST_DONE : ST_PTE_REQ;
        end
      end
      ST_PTE_REQ: begin
        memReqValid = 1'b1;
        stb.usePte  = 1'b1;
        stateNext   = ST_PTE_WAIT;
      end
      ST_PTE_WAIT: begin
        stb.usePte = 1'b1;
        if (memRspValid) begin
          stb.takePte = 1'b1;
          stateNext   = ST_DONE;
        end
      end
      ST_DONE: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  a_r1_bypass_next: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !xlateOn) |=> (rspValid && !memReqValid));

  a_r4_no_pte_after_segfault: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && stb.takeSte && steBad) |=> (rspValid && !memReqValid));

  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  a_r10_mem_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/iox_datapath.sv
module iox_datapath
  import iox_pkg::*;
#(
  parameter int IO_W = 36,
  parameter int PA_W = 52,
  parameter int ID_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  iox_strobe_t       stb,
  input  logic [63:0]       originReg,
  input  logic [IO_W-1:0]   reqAddr,
  input  logic              reqWrite,
  input  logic [ID_W-1:0]   reqId,
  input  logic [63:0]       memRspData,
  output logic [PA_W-1:0]   memReqAddr,
  output logic              steBad,
  output logic [PA_W-1:0]   rspAddr,
  output logic [1:0]        rspFault
);

  localparam int SEG_W = IO_W - SEG_SHIFT;
  localparam int PN_W  = PA_W - PG_MIN;
  localparam int IDX_W = SEG_SHIFT - PG_MIN;

  logic [IO_W-1:0] ioAddrQ;
  logic            writeQ;
  logic [ID_W-1:0] idQ;
  logic [PN_W-1:0] steBaseQ;
  logic [2:0]      steCodeQ;
  logic [PA_W-1:0] addrQ;
  iox_fault_e      faultQ;

  // segment entry fetch
  logic [SEG_W-1:0] segIdx;
  logic [PA_W-1:0]  steAddr;
  assign segIdx  = ioAddrQ[IO_W-1:SEG_SHIFT];
  assign steAddr = {originReg[PA_W-1:PG_MIN], {PG_MIN{1'b0}}} + PA_W'({segIdx, 3'b000});

  // checks on an arriving segment entry
  logic [4:0]       rspShift;
  logic [IDX_W-1:0] idxNew;
  logic [IDX_W:0]   limitNew;
  assign rspShift = pageShift(memRspData[2:0]);
  assign idxNew   = IDX_W'(ioAddrQ[SEG_SHIFT-1:0] >> rspShift);
  assign limitNew = ((IDX_W+1)'(memRspData[11:5]) + (IDX_W+1)'(1)) << 9;
  assign steBad   = !memRspData[63] || (rspShift == 5'd0) || ({1'b0, idxNew} >= limitNew);

  // page entry fetch
  logic [4:0]       stShift;
  logic [IDX_W-1:0] idxQ;
  logic [PA_W-1:0]  pteAddr;
  assign stShift = pageShift(steCodeQ);
  assign idxQ    = IDX_W'(ioAddrQ[SEG_SHIFT-1:0] >> stShift);
  assign pteAddr = {steBaseQ, {PG_MIN{1'b0}}} + PA_W'({idxQ, 3'b000});

  assign memReqAddr = stb.usePte ? pteAddr : steAddr;

  // checks on an arriving page entry and address splice
  logic            permOk, idOk, pteBad;
  logic [PA_W-1:0] offMask, realAddr;
  assign permOk   = writeQ ? memRspData[62] : memRspData[63];
  assign idOk     = (memRspData[ID_W-1:0] == idQ);
  assign pteBad   = (memRspData == 64'd0) || !permOk || !idOk;
  assign offMask  = (PA_W'(1) << stShift) - PA_W'(1);
  assign realAddr = ({memRspData[PA_W-1:PG_MIN], {PG_MIN{1'b0}}} & ~offMask)
                  | (PA_W'(ioAddrQ[SEG_SHIFT-1:0]) & offMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioAddrQ  <= '0;
      writeQ   <= 1'b0;
      idQ      <= '0;
      steBaseQ <= '0;
      steCodeQ <= '0;
      addrQ    <= '0;
      faultQ   <= FLT_NONE;
    end else begin
      if (stb.takeReq) begin
        ioAddrQ <= reqAddr;
        writeQ  <= reqWrite;
        idQ     <= reqId;
        faultQ  <= FLT_NONE;
        addrQ   <= stb.bypass ? PA_W'(reqAddr) : '0;
      end
      if (stb.takeSte) begin
        steBaseQ <= memRspData[PA_W-1:PG_MIN];
        steCodeQ <= memRspData[2:0];
        if (steBad) faultQ <= FLT_SEG;
      end
      if (stb.takePte) begin
        if (pteBad) begin
          faultQ <= FLT_PAGE;
          addrQ  <= '0;
        end else begin
          addrQ  <= realAddr;
        end
      end
    end
  end

  assign rspAddr  = addrQ;
  assign rspFault = faultQ;

  logic unusedBits;
  assign unusedBits = ^{originReg[63:PA_W], originReg[PG_MIN-1:0],
                        memRspData[61:PA_W], memRspData[4:3]};

  a_r7_fault_clears_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault != FLT_NONE) |-> (rspAddr == '0));

endmodule

// File: rtl/iox_walker.sv
module iox_walker
  import iox_pkg::*;
#(
  parameter int IO_W = 36,
  parameter int PA_W = 52,
  parameter int ID_W = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [63:0]     originReg,
  input  logic [63:0]     cmdCfg,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [IO_W-1:0] reqAddr,
  input  logic            reqWrite,
  input  logic [ID_W-1:0] reqId,
  output logic            memReqValid,
  output logic [PA_W-1:0] memReqAddr,
  input  logic            memRspValid,
  input  logic [63:0]     memRspData,
  output logic            rspValid,
  output logic [PA_W-1:0] rspAddr,
  output logic [1:0]      rspFault
);

  iox_strobe_t stb;
  logic        steBad;
  logic        xlateOn;

  assign xlateOn = originReg[63] & cmdCfg[47];

  logic unusedCfg;
  assign unusedCfg = ^{cmdCfg[63:48], cmdCfg[46:0]};

  iox_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .xlateOn     (xlateOn),
    .memRspValid (memRspValid),
    .steBad      (steBad),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .rspValid    (rspValid),
    .stb         (stb)
  );

  iox_datapath #(.IO_W(IO_W), .PA_W(PA_W), .ID_W(ID_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .originReg  (originReg),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .reqId      (reqId),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .steBad     (steBad),
    .rspAddr    (rspAddr),
    .rspFault   (rspFault)
  );

endmodule

// File: tb/iox_walker_bench.sv
module iox_walker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] originReg = 64'd0;
  logic [63:0] cmdCfg = 64'd0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [35:0] reqAddr = 36'd0;
  logic        reqWrite = 1'b0;
  logic [10:0] reqId = 11'd0;
  logic        memReqValid;
  logic [51:0] memReqAddr;
  logic        memRspValid;
  logic [63:0] memRspData;
  logic        rspValid;
  logic [51:0] rspAddr;
  logic [1:0]  rspFault;

  always #10 clk = ~clk;

  iox_walker u_iox_walker (
    .clk(clk), .rstN(rstN), .originReg(originReg), .cmdCfg(cmdCfg),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqId(reqId), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspFault(rspFault)
  );

  int nChecks = 0;
  int nFail = 0;

  logic [63:0] memA [logic [63:0]];
  logic [63:0] rdLog [4];
  int          rdCount;
  int          lastCyc;
  logic        lastPulseOk;
  logic        lastReadyLeak;
  logic [63:0] gotAddr;
  logic [63:0] gotFault;

  localparam logic [63:0] ORIGIN_ON = 64'h8000_0000_0010_0000;
  localparam logic [63:0] CFG_ON    = 64'h0000_8000_0000_0000;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkSte(input logic v, input logic [39:0] pg,
                                        input logic [6:0] nppt, input logic [2:0] code);
    return ({63'd0, v} << 63) | ({24'd0, pg} << 12) | ({57'd0, nppt} << 5) | {61'd0, code};
  endfunction

  function automatic logic [63:0] mkPte(input logic r, input logic w,
                                        input logic [39:0] rpn, input logic [10:0] id);
    return ({63'd0, r} << 63) | ({63'd0, w} << 62) | ({24'd0, rpn} << 12) | {53'd0, id};
  endfunction

  // memory responder: 2 cycles of latency after seeing a read
  initial begin
    logic [63:0] pendAddr;
    int pendCnt;
    pendAddr = 0; pendCnt = 0; rdCount = 0;
    memRspValid = 1'b0; memRspData = 64'd0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (memReqValid) begin
        if (rdCount < 4) rdLog[rdCount] = {12'd0, memReqAddr};
        rdCount++;
        pendAddr = {12'd0, memReqAddr};
        pendCnt = 2;
      end else if (pendCnt > 0) begin
        pendCnt--;
        if (pendCnt == 0) begin
          memRspValid = 1'b1;
          memRspData = memA.exists(pendAddr) ? memA[pendAddr] : 64'd0;
        end
      end
    end
  end

  task automatic doXlate(input logic [63:0] io, input logic wr, input logic [10:0] id);
    int cyc;
    rdCount = 0;
    for (int k = 0; k < 4; k++) rdLog[k] = '1;
    lastReadyLeak = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = io[35:0]; reqWrite = wr; reqId = id;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (!rspValid && cyc < 60) begin
      if (reqReady) lastReadyLeak = 1'b1;
      @(negedge clk);
      cyc++;
    end
    lastCyc  = cyc;
    gotAddr  = {12'd0, rspAddr};
    gotFault = {62'd0, rspFault};
    @(negedge clk);
    lastPulseOk = !rspValid && reqReady;
  endtask

  task automatic tReset();
    chk("R10 reset ready", {63'd0, reqReady}, 64'd1);
    chk("R10 reset rspValid", {63'd0, rspValid}, 64'd0);
    chk("R10 reset memReqValid", {63'd0, memReqValid}, 64'd0);
  endtask

  task automatic tBypass();
    originReg = 64'h0000_0000_0010_0000; cmdCfg = CFG_ON;
    doXlate(64'h3_2345_6789, 1'b0, 11'd5);
    chk("R1 bypass addr (origin off)", gotAddr, 64'h3_2345_6789);
    chk("R1 bypass fault", gotFault, 64'd0);
    chk("R1 bypass reads", rdCount, 0);
    chk("R1 bypass latency", lastCyc, 0);
    originReg = ORIGIN_ON; cmdCfg = 64'd0;
    doXlate(64'h0_0000_0ABC, 1'b1, 11'd1);
    chk("R1 bypass addr (cfg off)", gotAddr, 64'h0ABC);
    chk("R1 bypass reads (cfg off)", rdCount, 0);
    cmdCfg = CFG_ON;
  endtask

  task automatic tPage4k();
    doXlate(64'h3001_2345, 1'b0, 11'd5);
    chk("R2 ste address", rdLog[0], 64'h100018);
    chk("R6 pte address", rdLog[1], 64'h200090);
    chk("R3 4K real address", gotAddr, 64'hABCDE345);
    chk("R3 4K fault", gotFault, 64'd0);
    chk("R10 two reads", rdCount, 2);
    chk("R10 rsp pulse and ready", {63'd0, lastPulseOk}, 64'd1);
    chk("R10 ready low while busy", {63'd0, lastReadyLeak}, 64'd0);
  endtask

  task automatic tSizes();
    doXlate(64'h1034_5678, 1'b1, 11'd5);
    chk("R6 64K pte address", rdLog[1], 64'h3001A0);
    chk("R3 64K real address", gotAddr, 64'h1234_5678);
    doXlate(64'h20AB_CDEF, 1'b0, 11'd5);
    chk("R6 1M pte address", rdLog[1], 64'h400050);
    chk("R3 1M real address", gotAddr, 64'h555B_CDEF);
    doXlate(64'h4512_3456, 1'b0, 11'd5);
    chk("R6 16M pte address", rdLog[1], 64'h500028);
    chk("R3 16M real address masks rpn", gotAddr, 64'h7712_3456);
  endtask

  task automatic tSegFault();
    doXlate(64'h5000_1000, 1'b0, 11'd5);
    chk("R4 invalid ste fault", gotFault, 64'd1);
    chk("R4 invalid ste one read", rdCount, 1);
    chk("R7 fault addr zero", gotAddr, 64'd0);
    doXlate(64'h6000_1000, 1'b0, 11'd5);
    chk("R4 bad size code fault", gotFault, 64'd1);
    chk("R4 bad size one read", rdCount, 1);
  endtask

  task automatic tBounds();
    doXlate(64'h701F_F000, 1'b0, 11'd5);
    chk("R5 last index ok addr", gotAddr, 64'h1111_1000);
    chk("R5 last index pte addr", rdLog[1], 64'h600FF8);
    doXlate(64'h7020_0000, 1'b0, 11'd5);
    chk("R5 index past length fault", gotFault, 64'd1);
    chk("R5 no pte read", rdCount, 1);
    memA[64'h100038] = mkSte(1'b1, 40'h600, 7'd1, 3'b001);
    doXlate(64'h7020_0000, 1'b0, 11'd5);
    chk("R5 longer table addr", gotAddr, 64'h2222_2000);
    chk("R6 second table page", rdLog[1], 64'h601000);
  endtask

  task automatic tPageFault();
    doXlate(64'h3002_0000, 1'b0, 11'd5);
    chk("R7 zero pte fault", gotFault, 64'd2);
    chk("R7 zero pte addr", gotAddr, 64'd0);
    doXlate(64'h3002_1ABC, 1'b1, 11'd5);
    chk("R8 write to read-only", gotFault, 64'd2);
    doXlate(64'h3002_1ABC, 1'b0, 11'd5);
    chk("R8 read of read-only", gotAddr, 64'h3333_3ABC);
    doXlate(64'h3002_2010, 1'b0, 11'd5);
    chk("R8 read of write-only", gotFault, 64'd2);
    doXlate(64'h3002_2010, 1'b1, 11'd5);
    chk("R8 write of write-only", gotAddr, 64'h4444_4010);
    doXlate(64'h3001_2345, 1'b0, 11'd6);
    chk("R9 id mismatch fault", gotFault, 64'd2);
    chk("R9 id mismatch addr", gotAddr, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R10 act=hung exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    memA[64'h100018] = mkSte(1'b1, 40'h200, 7'd0, 3'b001);
    memA[64'h100008] = mkSte(1'b1, 40'h300, 7'd0, 3'b011);
    memA[64'h100010] = mkSte(1'b1, 40'h400, 7'd0, 3'b101);
    memA[64'h100020] = mkSte(1'b1, 40'h500, 7'd0, 3'b111);
    memA[64'h100030] = mkSte(1'b1, 40'h200, 7'd0, 3'b000);
    memA[64'h100038] = mkSte(1'b1, 40'h600, 7'd0, 3'b001);
    memA[64'h200090] = mkPte(1'b1, 1'b1, 40'hABCDE, 11'd5);
    memA[64'h3001A0] = mkPte(1'b1, 1'b1, 40'h12340, 11'd5);
    memA[64'h400050] = mkPte(1'b1, 1'b1, 40'h55500, 11'd5);
    memA[64'h500028] = mkPte(1'b1, 1'b1, 40'h77FFF, 11'd5);
    memA[64'h600FF8] = mkPte(1'b1, 1'b1, 40'h11111, 11'd5);
    memA[64'h601000] = mkPte(1'b1, 1'b1, 40'h22222, 11'd5);
    memA[64'h200108] = mkPte(1'b1, 1'b0, 40'h33333, 11'd5);
    memA[64'h200110] = mkPte(1'b0, 1'b1, 40'h44444, 11'd5);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBypass();
    originReg = ORIGIN_ON; cmdCfg = CFG_ON;
    tPage4k();
    tSizes();
    tSegFault();
    tBounds();
    tPageFault();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule